// File: doc/BRIEF.md
# Timer Channel Register Front End

This block is the byte-wide programming port placed before three counter channels. A host writes control words and count bytes through a 2-bit address and an 8-bit data bus, and reads count and status bytes back. The block decodes the control words and splits each 16-bit count into byte transfers. It also holds a frozen count snapshot and a status snapshot for each channel. When a count is complete, it sends that channel a one-cycle load pulse with the count, the mode and the BCD flag.

The counting itself lives in the channel blocks. They return their live 16-bit count and their output level to this block. Read data is combinational and valid during the cycle in which the read strobe is high. The side effects of that read, such as releasing a snapshot or advancing the byte pointer, take effect at the clock edge that ends the cycle. The block also drives the three channel gate levels. Channels 0 and 1 are held high. Channel 2 follows a registered request input.

Top module: `tmr_regif`

## Requirements
- R1: Address 3 is the control port and addresses 0, 1 and 2 are the data ports of channels 0, 1 and 2. In a control byte, bits 7:6 pick the channel, bits 5:4 the access type (0 snapshot count, 1 low byte only, 2 high byte only, 3 low then high), bits 3:1 the mode and bit 0 the BCD flag.
- R2: A mode field of 6 or 7 is stored and reported as 2 or 3 respectively.
- R3: A count write loads the byte as the count in low-only access, and the byte times 256 in high-only access. In word access, the first byte is held and the second byte loads {second, first}. The load pulse, count, mode and BCD outputs appear in the cycle after the completing write, for that channel only.
- R4: With no snapshot pending, a read returns the live count: the low byte for low-only access, the high byte for high-only access, and in word access the low then high byte, alternating.
- R5: Access type 0 freezes the channel's live count. In word access the frozen value is released only after its high byte has been read. Later reads then return the live count again.
- R6: A count or status snapshot request is ignored while an earlier snapshot of the same kind on that channel is still unread.
- R7: A control byte with bits 7:6 = 3 is a multi-channel command. Bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 at 0 requests a count snapshot and bit 4 at 0 requests a status snapshot on each selected channel. Unselected channels are untouched.
- R8: A status byte is {output level, 0, access[1:0], mode[2:0], BCD}. A pending status byte is returned and cleared on the next read, before any pending count snapshot.
- R9: A control byte with a nonzero access type returns that channel's read and write byte pointers to the low byte.
- R10: After reset every channel has low-byte-only access, mode 0, BCD 0 and no pending snapshot, and no load pulse is active.
- R11: Gate levels are bit 0 = channel 0, bit 1 = channel 1, bit 2 = channel 2. After reset they are 3'b011. Channel 2's gate follows the request input one cycle later.
- R12: A read of address 3 returns 8'hFF and changes no channel state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 2 | Port select: 0..2 channel data, 3 control |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| rd_en | input | 1 | Read strobe, one byte per cycle |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while rd_en is high |
| live_cnt | input | 48 | Live counts, channel i in bits 16i+15:16i |
| chan_out | input | 3 | Output level of each channel |
| gate2_req | input | 1 | Requested gate level for channel 2 |
| gate_lvl | output | 3 | Gate level per channel |
| load_stb | output | 3 | One-cycle load pulse per channel |
| load_count | output | 48 | Count to load, channel i in bits 16i+15:16i |
| load_mode | output | 9 | Mode per channel, channel i in bits 3i+2:3i |
| load_bcd | output | 3 | BCD flag per channel |

## Verification
A corrupted byte pointer shows up as swapped high and low bytes. This appears on the next word-access read, or as a wrong load value on the second write of a word. A stuck snapshot flag shows up as a frozen value returned after the live count has moved. The wrong value then persists on every later read of that channel, and a stuck status flag does the same. A mis-decoded command shows up at the next status read of the affected channel, because the status byte echoes the stored access type, mode and BCD flag. Each of these faults is therefore visible within one or two bus reads, and the bench changes the live counts between snapshot and read so that frozen and live values differ.

// File: rtl/tmr_pkg.sv
// Shared types and helpers for the timer register front end.
// Assumes 16-bit counts transferred as two bytes.
package tmr_pkg;

    localparam int BYTE_W  = 8;
    localparam int COUNT_W = 2 * BYTE_W;

    // Access type; ACC_NONE doubles as "no count snapshot pending".
    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_LO   = 2'd1,
        ACC_HI   = 2'd2,
        ACC_WORD = 2'd3
    } acc_e;

    // Folds mode codes 6 and 7 onto 2 and 3.
    function automatic logic [2:0] fold_mode(input logic [2:0] m);
        return (m[2:1] == 2'b11) ? {1'b0, m[1:0]} : m;
    endfunction

endpackage

// File: rtl/tmr_cmd_decode.sv
// Decodes one bus cycle into per-channel strobes.
// Assumes at most one of wr_en / rd_en is high in a cycle.
module tmr_cmd_decode #(
    parameter int NUM_CH = 3
) (
    input  logic [1:0]        addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [7:0]        wdata,
    output logic [NUM_CH-1:0] ctl_wr,
    output logic [NUM_CH-1:0] cnt_req,
    output logic [NUM_CH-1:0] st_req,
    output logic [NUM_CH-1:0] data_wr,
    output logic [NUM_CH-1:0] data_rd
);
    localparam logic [1:0] CTL_ADDR = 2'd3;

    logic is_ctl;
    logic multi_cmd;

    // Control-port write and multi-channel command detection.
    always_comb begin
        is_ctl    = wr_en && (addr == CTL_ADDR);
        multi_cmd = is_ctl && (wdata[7:6] == 2'b11);
    end

    // Per-channel strobe generation.
    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            data_wr[i] = wr_en && (addr == 2'(i));
            data_rd[i] = rd_en && (addr == 2'(i));
            if (multi_cmd) begin
                ctl_wr[i]  = 1'b0;
                cnt_req[i] = wdata[1+i] && !wdata[5];
                st_req[i]  = wdata[1+i] && !wdata[4];
            end else begin
                ctl_wr[i]  = is_ctl && (wdata[7:6] == 2'(i)) && (wdata[5:4] != 2'b00);
                cnt_req[i] = is_ctl && (wdata[7:6] == 2'(i)) && (wdata[5:4] == 2'b00);
                st_req[i]  = 1'b0;
            end
        end
    end

endmodule

// File: rtl/tmr_chan_port.sv
// Register state of one channel: access type, mode, BCD, byte pointers,
// count snapshot and status snapshot. Read byte is combinational; all
// side effects land on the clock edge. Assumes the decoder never raises
// a control write and a snapshot request together.
module tmr_chan_port
    import tmr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctl_wr,
    input  logic [5:0]         ctl_byte,
    input  logic               cnt_req,
    input  logic               st_req,
    input  logic               data_wr,
    input  logic               data_rd,
    input  logic [BYTE_W-1:0]  wdata,
    input  logic [COUNT_W-1:0] live,
    input  logic               out_lvl,
    output logic [BYTE_W-1:0]  rd_byte,
    output logic               load_stb,
    output logic [COUNT_W-1:0] load_val,
    output logic [2:0]         load_mode,
    output logic               load_bcd
);
    acc_e               acc_q;
    acc_e               lat_q;
    logic [2:0]         mode_q;
    logic               bcd_q;
    logic               wr_hi_q;
    logic               rd_hi_q;
    logic [BYTE_W-1:0]  hold_q;
    logic [COUNT_W-1:0] snap_q;
    logic [BYTE_W-1:0]  st_q;
    logic               st_vld_q;

    // Channel register update: reads, writes, commands, snapshots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q     <= ACC_LO;
            lat_q     <= ACC_NONE;
            mode_q    <= 3'd0;
            bcd_q     <= 1'b0;
            wr_hi_q   <= 1'b0;
            rd_hi_q   <= 1'b0;
            hold_q    <= '0;
            snap_q    <= '0;
            st_q      <= '0;
            st_vld_q  <= 1'b0;
            load_stb  <= 1'b0;
            load_val  <= '0;
            load_mode <= 3'd0;
            load_bcd  <= 1'b0;
        end else begin
            load_stb <= 1'b0;
            if (data_rd) begin
                if (st_vld_q) begin
                    st_vld_q <= 1'b0;
                end else if (lat_q != ACC_NONE) begin
                    lat_q <= (lat_q == ACC_WORD) ? ACC_HI : ACC_NONE;
                end else if (acc_q == ACC_WORD) begin
                    rd_hi_q <= !rd_hi_q;
                end
            end
            if (data_wr) begin
                load_mode <= mode_q;
                load_bcd  <= bcd_q;
                case (acc_q)
                    ACC_HI: begin
                        load_stb <= 1'b1;
                        load_val <= {wdata, 8'h00};
                    end
                    ACC_WORD: begin
                        if (wr_hi_q) begin
                            load_stb <= 1'b1;
                            load_val <= {wdata, hold_q};
                        end else begin
                            hold_q <= wdata;
                        end
                        wr_hi_q <= !wr_hi_q;
                    end
                    default: begin
                        load_stb <= 1'b1;
                        load_val <= {8'h00, wdata};
                    end
                endcase
            end
            if (ctl_wr) begin
                acc_q   <= acc_e'(ctl_byte[5:4]);
                mode_q  <= fold_mode(ctl_byte[3:1]);
                bcd_q   <= ctl_byte[0];
                wr_hi_q <= 1'b0;
                rd_hi_q <= 1'b0;
            end
            if (cnt_req && (lat_q == ACC_NONE)) begin
                snap_q <= live;
                lat_q  <= acc_q;
            end
            if (st_req && !st_vld_q) begin
                st_q     <= {out_lvl, 1'b0, acc_q, mode_q, bcd_q};
                st_vld_q <= 1'b1;
            end
        end
    end

    // Read byte selection: status, then snapshot, then live count.
    always_comb begin
        if (st_vld_q) begin
            rd_byte = st_q;
        end else if (lat_q == ACC_HI) begin
            rd_byte = snap_q[15:8];
        end else if (lat_q != ACC_NONE) begin
            rd_byte = snap_q[7:0];
        end else begin
            case (acc_q)
                ACC_HI:   rd_byte = live[15:8];
                ACC_WORD: rd_byte = rd_hi_q ? live[15:8] : live[7:0];
                default:  rd_byte = live[7:0];
            endcase
        end
    end

    // A pending status byte survives every cycle without a read (R8).
    assert_status_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_vld_q && !data_rd) |=> st_vld_q);

    // A pending count snapshot is not overwritten by new requests (R6).
    assert_snapshot_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_q != ACC_NONE && !data_rd) |=> $stable(snap_q));

    // A load pulse is always caused by a data write one cycle earlier (R3).
    assert_load_after_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |-> $past(data_wr));

    // Stored mode never holds the unfolded codes 6 or 7 (R2).
    assert_mode_folded_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (mode_q[2:1] != 2'b11));

endmodule

// File: rtl/tmr_regif.sv
// Top of the timer register front end: decodes the bus, keeps one
// register slice per channel, muxes read data and drives gate levels.
// Assumes one bus access per cycle and NUM_CH <= 3 (2-bit address).
module tmr_regif
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [1:0]                addr,
    input  logic                      wr_en,
    input  logic                      rd_en,
    input  logic [7:0]                wdata,
    output logic [7:0]                rdata,
    input  logic [NUM_CH*COUNT_W-1:0] live_cnt,
    input  logic [NUM_CH-1:0]         chan_out,
    input  logic                      gate2_req,
    output logic [NUM_CH-1:0]         gate_lvl,
    output logic [NUM_CH-1:0]         load_stb,
    output logic [NUM_CH*COUNT_W-1:0] load_count,
    output logic [NUM_CH*3-1:0]       load_mode,
    output logic [NUM_CH-1:0]         load_bcd
);
    localparam int LAST_CH = NUM_CH - 1;

    logic [NUM_CH-1:0] ctl_wr, cnt_req, st_req, data_wr, data_rd;
    logic [7:0]        ch_rd [NUM_CH];
    logic              gate_last_q;

    tmr_cmd_decode #(.NUM_CH(NUM_CH)) u_dec (
        .addr    (addr),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .wdata   (wdata),
        .ctl_wr  (ctl_wr),
        .cnt_req (cnt_req),
        .st_req  (st_req),
        .data_wr (data_wr),
        .data_rd (data_rd)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        tmr_chan_port u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .ctl_wr    (ctl_wr[g]),
            .ctl_byte  (wdata[5:0]),
            .cnt_req   (cnt_req[g]),
            .st_req    (st_req[g]),
            .data_wr   (data_wr[g]),
            .data_rd   (data_rd[g]),
            .wdata     (wdata),
            .live      (live_cnt[g*COUNT_W +: COUNT_W]),
            .out_lvl   (chan_out[g]),
            .rd_byte   (ch_rd[g]),
            .load_stb  (load_stb[g]),
            .load_val  (load_count[g*COUNT_W +: COUNT_W]),
            .load_mode (load_mode[g*3 +: 3]),
            .load_bcd  (load_bcd[g])
        );
    end

    // Read data mux; the control address reads as all ones.
    always_comb begin
        rdata = 8'hFF;
        for (int i = 0; i < NUM_CH; i++) begin
            if (addr == 2'(i)) rdata = ch_rd[i];
        end
    end

    // Last channel's gate follows its request; it starts low.
    always_ff @(posedge clk) begin
        if (!rst_n) gate_last_q <= 1'b0;
        else        gate_last_q <= gate2_req;
    end

    // Gate levels: all channels high except the last one.
    always_comb begin
        gate_lvl          = '1;
        gate_lvl[LAST_CH] = gate_last_q;
    end

    // Only one channel receives a load pulse per cycle (R3).
    assert_one_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load_stb));

    // The last channel's gate tracks its request one cycle later (R11).
    assert_gate_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        gate2_req |=> gate_lvl[LAST_CH]);

endmodule

// File: tb/tb_tmr_regif.sv
module tb_tmr_regif;
    localparam int CLK_P = 10;
    localparam int NV    = 14;
    // {op(2): 0 read-check, 1 write; addr(2); wdata(8); expected(8)}
    localparam logic [19:0] VEC [NV] = '{
        {2'd0, 2'd0, 8'h00, 8'hB2},  // R10 reset access low byte
        {2'd1, 2'd3, 8'h74, 8'h00},  // R1 ch1 word mode 2
        {2'd0, 2'd1, 8'h00, 8'hD4},  // R4 low
        {2'd0, 2'd1, 8'h00, 8'hC3},  // R4 high
        {2'd0, 2'd1, 8'h00, 8'hD4},  // R4 low again
        {2'd1, 2'd3, 8'hAF, 8'h00},  // R2 ch2 high-only mode 7 bcd
        {2'd0, 2'd2, 8'h00, 8'hE5},  // R1 high byte
        {2'd1, 2'd3, 8'hE8, 8'h00},  // R7 status of ch2
        {2'd0, 2'd2, 8'h00, 8'hA7},  // R8 status byte, mode 3
        {2'd0, 2'd2, 8'h00, 8'hE5},  // R8 cleared, live again
        {2'd1, 2'd3, 8'h30, 8'h00},  // R1 ch0 word
        {2'd0, 2'd0, 8'h00, 8'hB2},
        {2'd0, 2'd0, 8'h00, 8'hA1},
        {2'd0, 2'd3, 8'h00, 8'hFF}   // R12
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  addr = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [47:0] live_cnt = '0;
    logic [2:0]  chan_out = '0;
    logic        gate2_req = 1'b0;
    logic [2:0]  gate_lvl, load_stb, load_bcd;
    logic [47:0] load_count;
    logic [8:0]  load_mode;
    int          errors = 0, checks = 0;

    tmr_regif dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .live_cnt(live_cnt), .chan_out(chan_out),
        .gate2_req(gate2_req), .gate_lvl(gate_lvl), .load_stb(load_stb),
        .load_count(load_count), .load_mode(load_mode), .load_bcd(load_bcd)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 chk(tag, {40'd0, rdata}, {40'd0, exp});
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        live_cnt = {16'hE5F6, 16'hC3D4, 16'hA1B2};
        chan_out = 3'b101;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 no load pulse after reset", {45'd0, load_stb}, 48'd0);
        chk("R11 gate reset levels", {45'd0, gate_lvl}, {45'd0, 3'b011});

        for (int v = 0; v < NV; v++) begin
            if (VEC[v][19:18] == 2'd1) wr(VEC[v][17:16], VEC[v][15:8]);
            else rd(VEC[v][17:16], VEC[v][7:0], $sformatf("R1/R4/R2/R8/R12 vector %0d", v));
        end

        // R3 write sequencing and load outputs
        wr(2'd3, 8'h36);            // ch0 word, mode 3
        wr(2'd0, 8'h34);
        chk("R3 no load after first word byte", {45'd0, load_stb}, 48'd0);
        wr(2'd0, 8'h12);
        chk("R3 word load pulse", {45'd0, load_stb}, {45'd0, 3'b001});
        chk("R3 word load value", {32'd0, load_count[15:0]}, 48'h1234);
        chk("R3 word load mode", {45'd0, load_mode[2:0]}, 48'd3);
        wr(2'd3, 8'h52);            // ch1 low-only, mode 1
        wr(2'd1, 8'h77);
        chk("R3 low-only load", {31'd0, load_stb[1], load_count[31:16]}, {31'd0, 1'b1, 16'h0077});
        chk("R3 low-only mode", {45'd0, load_mode[5:3]}, 48'd1);
        wr(2'd3, 8'hAD);            // ch2 high-only, mode 6 -> 2, bcd
        wr(2'd2, 8'h99);
        chk("R3 high-only load", {31'd0, load_stb[2], load_count[47:32]}, {31'd0, 1'b1, 16'h9900});
        chk("R2 mode 6 folded to 2", {44'd0, load_bcd[2], load_mode[8:6]}, {44'd0, 1'b1, 3'd2});

        // R5 snapshot freezes and releases after high byte
        wr(2'd3, 8'h30);
        live_cnt[15:0] = 16'h1234;
        wr(2'd3, 8'h00);
        live_cnt[15:0] = 16'h5678;
        rd(2'd0, 8'h34, "R5 snapshot low");
        live_cnt[15:0] = 16'h9A99;
        rd(2'd0, 8'h12, "R5 snapshot high");
        rd(2'd0, 8'h99, "R5 released to live");
        rd(2'd0, 8'h9A, "R5 live high");

        // R6 second snapshot ignored while first unread
        live_cnt[15:0] = 16'h1111;
        wr(2'd3, 8'h00);
        live_cnt[15:0] = 16'h2222;
        wr(2'd3, 8'h00);
        rd(2'd0, 8'h11, "R6 first snapshot kept low");
        rd(2'd0, 8'h11, "R6 first snapshot kept high");
        rd(2'd0, 8'h22, "R6 live after release");
        rd(2'd0, 8'h22, "R6 live high");

        // R8 status priority over count snapshot
        wr(2'd3, 8'h74);
        live_cnt[31:16] = 16'hABCD;
        chan_out[1] = 1'b0;
        wr(2'd3, 8'hC4);
        live_cnt[31:16] = 16'h0000;
        rd(2'd1, 8'h34, "R8 status first");
        rd(2'd1, 8'hCD, "R8 then snapshot low");
        rd(2'd1, 8'hAB, "R8 then snapshot high");

        // R7 multi-channel count snapshot on ch0 and ch1 only
        live_cnt = {16'h5566, 16'h0304, 16'h0102};
        wr(2'd3, 8'hD6);
        live_cnt = {16'h7788, 16'hFFFF, 16'hFFFF};
        rd(2'd0, 8'h02, "R7 ch0 low");
        rd(2'd0, 8'h01, "R7 ch0 high");
        rd(2'd1, 8'h04, "R7 ch1 low");
        rd(2'd1, 8'h03, "R7 ch1 high");
        rd(2'd2, 8'h77, "R7 ch2 unselected live");

        // R9 control byte resets both byte pointers
        wr(2'd3, 8'h30);
        live_cnt[15:0] = 16'h1234;
        rd(2'd0, 8'h34, "R9 read low");
        wr(2'd3, 8'h30);
        rd(2'd0, 8'h34, "R9 read pointer back to low");
        wr(2'd0, 8'h55);
        wr(2'd3, 8'h30);
        wr(2'd0, 8'h66);
        chk("R9 write pointer back to low", {45'd0, load_stb}, 48'd0);
        wr(2'd0, 8'h77);
        chk("R9 word after reset", {32'd0, load_count[15:0]}, 48'h7766);

        // R12 control read has no effect
        rd(2'd3, 8'hFF, "R12 control read");
        rd(2'd0, 8'h34, "R12 ch0 pointer untouched");

        // R11 gate follows request
        @(negedge clk);
        gate2_req = 1'b1;
        @(negedge clk);
        chk("R11 gate2 high", {45'd0, gate_lvl}, {45'd0, 3'b111});
        gate2_req = 1'b0;
        @(negedge clk);
        chk("R11 gate2 low", {45'd0, gate_lvl}, {45'd0, 3'b011});

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule